// File: doc/BRIEF.md
# GPIO Controller with Edge-Cause Interrupts

This block is a memory-mapped general-purpose I/O controller for up to 32 pins. The pin count is a parameter, so one design also serves narrower instances such as a 24-pin bank. A simple register bus selects one of four regions with a two-bit region code and a byte offset. The four regions are edge configuration and input, interrupt cause, a write-one-to-set window and a write-one-to-clear window. Because of the two windows, software can change the output-enable bit or the output data bit of a single pin without a read-modify-write sequence.

Each pin input passes through a two-flop synchroniser. After that it feeds an edge detector with separate enables for rising edges and falling edges. A detected edge sets a sticky cause bit, and the cause bit holds until software writes a one to it through the cause-clear offset. An event-enable mask selects which cause bits are visible. The OR of the visible cause bits is registered and drives one shared, level-sensitive interrupt line. The pads are driven through a data bit and an output-enable bit for each pin. The external pad cell goes to high impedance whenever the enable is low.

Top module: `gpio_edge_ctrl`

## Requirements
- R1: In the set region (region code 2), a write to offset 0x00 ORs the written bits into the output-enable register, and a write to offset 0x04 ORs them into the output-data register. Bits written as 0 are unchanged. Reads at those two offsets of region 2 or region 3 return the current output-enable and output-data values.
- R2: In the clear region (region code 3), a write to offset 0x00 clears every output-enable bit written as 1, and a write to offset 0x04 clears every output-data bit written as 1. Bits written as 0 are unchanged.
- R3: `pad_oe` equals the output-enable register. `pad_o` carries the output-data bit where the enable is 1 and 0 where it is 0, and the pad cell is high impedance where the enable is 0.
- R4: A read at offset 0x08 of the configuration region (region code 0) returns the pin inputs after a two-flop synchroniser. A pin change made just after clock edge k becomes readable after edge k+2 and not before.
- R5: Configuration offset 0x00 is the read/write rising-edge enable and offset 0x04 is the read/write falling-edge enable. An enabled edge sets the pin's cause bit one edge after the synchronised value changes. With both enables set, either edge sets the cause bit. With neither enable set, no edge does.
- R6: Cause bits are sticky. Cause-region (region code 1) offset 0x00 reads the cause bits ANDed with the read/write event-enable mask at offset 0x14. A cause that latched while masked becomes visible when it is unmasked, and it can be cleared while still masked.
- R7: Writing ones to cause-region offset 0x18 clears those cause bits, and zeros have no effect. If an edge is detected in the same cycle as the clear for that pin, the cause bit stays set.
- R8: `irq` is a registered level. It is 1 in the cycle after any visible (masked) cause bit is 1, and it is 0 one cycle after all visible cause bits are 0.
- R9: Register bits at or above the `NPINS` parameter ignore writes and read as 0.
- R10: Reset (synchronous, active low) clears the output-enable, output-data, both edge enables, the event mask, all cause bits and `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_region | input | 2 | Region select: 0 config, 1 cause, 2 set, 3 clear |
| bus_addr | input | 5 | Byte offset within the region |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe; read data is valid in the same cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, 0 when no read is active |
| pad_i | input | NPINS | Asynchronous pin inputs |
| pad_o | output | NPINS | Pin output data, qualified by enable |
| pad_oe | output | NPINS | Pin output enable (1 drives the pad) |
| irq | output | 1 | Shared interrupt, level, registered |

## Verification
The bench builds the controller with `NPINS` set to 24, the reduced instance. This lets the bench write all-ones patterns and check that bits 24 to 31 stay at 0 in every register, which a 32-pin build could not show. With 24 pins the edge and cause paths, the set and clear windows and the read mux are still exercised in their full form. The bench also times a cause-clear write so that it falls in the exact cycle in which a synchronised edge is detected.

// File: rtl/gpio_edge_pkg.sv
// Package: shared constants and region codes for the GPIO edge controller.
// Assumes a 32-bit data bus and byte offsets of five bits.
package gpio_edge_pkg;
    localparam int BUS_DW = 32;
    localparam int BUS_AW = 5;

    typedef enum logic [1:0] {
        RGN_CFG   = 2'd0,
        RGN_CAUSE = 2'd1,
        RGN_SET   = 2'd2,
        RGN_CLR   = 2'd3
    } region_e;

    // Offsets inside the set and clear windows
    localparam logic [BUS_AW-1:0] OFF_OE     = 5'h00;
    localparam logic [BUS_AW-1:0] OFF_DOUT   = 5'h04;
    // Offsets inside the configuration region
    localparam logic [BUS_AW-1:0] OFF_RISE   = 5'h00;
    localparam logic [BUS_AW-1:0] OFF_FALL   = 5'h04;
    localparam logic [BUS_AW-1:0] OFF_PIN    = 5'h08;
    // Offsets inside the cause region
    localparam logic [BUS_AW-1:0] OFF_VIS    = 5'h00;
    localparam logic [BUS_AW-1:0] OFF_EVMASK = 5'h14;
    localparam logic [BUS_AW-1:0] OFF_CAUSECLR = 5'h18;
endpackage

// File: rtl/gpio_sync.sv
// Module: gpio_sync
// Multi-stage synchroniser for a vector of asynchronous inputs.
// Assumes each bit is independent (no bus coherency is needed across bits).
module gpio_sync #(
    parameter int W      = 32,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stg [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // First stage captures the raw pad value
                always_ff @(posedge clk) begin
                    if (!rst_n) stg[0] <= '0;
                    else        stg[0] <= din;
                end
            end else begin : g_next
                // Later stages resolve metastability
                always_ff @(posedge clk) begin
                    if (!rst_n) stg[s] <= '0;
                    else        stg[s] <= stg[s-1];
                end
            end
        end
    endgenerate

    assign dout = stg[STAGES-1];
endmodule

// File: rtl/gpio_out_regs.sv
// Module: gpio_out_regs
// Output-enable and output-data registers, updated by set and clear masks.
// Drives the pad enable and qualified pad data.
// Assumes the decoder never asserts set and clear of the same register in one cycle.
module gpio_out_regs #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_oe,
    input  logic [W-1:0] clr_oe,
    input  logic [W-1:0] set_do,
    input  logic [W-1:0] clr_do,
    output logic [W-1:0] oe_q,
    output logic [W-1:0] do_q,
    output logic [W-1:0] pad_o,
    output logic [W-1:0] pad_oe
);
    // Output-enable register: bitwise set and clear
    always_ff @(posedge clk) begin
        if (!rst_n) oe_q <= '0;
        else        oe_q <= (oe_q | set_oe) & ~clr_oe;
    end

    // Output-data register: bitwise set and clear
    always_ff @(posedge clk) begin
        if (!rst_n) do_q <= '0;
        else        do_q <= (do_q | set_do) & ~clr_do;
    end

    // Pad drive: data only where enabled, the pad cell floats otherwise
    always_comb begin
        pad_oe = oe_q;
        pad_o  = do_q & oe_q;
    end

    assert_set_oe_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (set_oe != '0 && clr_oe == '0) |=> ((oe_q & $past(set_oe)) == $past(set_oe)));

    assert_clr_do_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_do != '0) |=> ((do_q & $past(clr_do)) == '0));

    assert_reset_R10: assert property (@(posedge clk)
        !rst_n |=> (oe_q == '0 && do_q == '0));
endmodule

// File: rtl/gpio_edge_cause.sv
// Module: gpio_edge_cause
// Per-pin edge detection on synchronised inputs with sticky cause latches.
// Assumes din_s is already synchronous to clk. A detected edge has priority
// over a clear request in the same cycle.
module gpio_edge_cause #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din_s,
    input  logic [W-1:0] rise_en,
    input  logic [W-1:0] fall_en,
    input  logic [W-1:0] clr,
    output logic [W-1:0] cause_q
);
    logic [W-1:0] din_d;
    logic [W-1:0] hit;

    // Previous synchronised value for edge comparison
    always_ff @(posedge clk) begin
        if (!rst_n) din_d <= '0;
        else        din_d <= din_s;
    end

    // Enabled edges of either polarity
    always_comb begin
        hit = (rise_en & din_s & ~din_d) | (fall_en & ~din_s & din_d);
    end

    // Sticky cause: cleared on request, set by an edge which wins any tie
    always_ff @(posedge clk) begin
        if (!rst_n) cause_q <= '0;
        else        cause_q <= (cause_q & ~clr) | hit;
    end

    assert_edge_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (hit != '0) |=> ((cause_q & $past(hit)) == $past(hit)));

    assert_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cause_q != '0) |=> ((($past(cause_q) & ~$past(clr)) & ~cause_q) == '0));
endmodule

// File: rtl/gpio_edge_ctrl.sv
// Module: gpio_edge_ctrl (top)
// Memory-mapped GPIO bank: bus decode, edge configuration, event mask,
// read mux and registered shared interrupt.
// Assumes single-cycle bus strobes and a read data path with no wait state.
module gpio_edge_ctrl #(
    parameter int NPINS = 32
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic [1:0]                         bus_region,
    input  logic [gpio_edge_pkg::BUS_AW-1:0]   bus_addr,
    input  logic                               bus_wr,
    input  logic                               bus_rd,
    input  logic [gpio_edge_pkg::BUS_DW-1:0]   bus_wdata,
    output logic [gpio_edge_pkg::BUS_DW-1:0]   bus_rdata,
    input  logic [NPINS-1:0]                   pad_i,
    output logic [NPINS-1:0]                   pad_o,
    output logic [NPINS-1:0]                   pad_oe,
    output logic                               irq
);
    import gpio_edge_pkg::*;

    localparam int DW = BUS_DW;

    logic [NPINS-1:0] wbits;
    logic             wr_cfg, wr_cause, wr_set, wr_clr;
    logic [NPINS-1:0] set_oe, clr_oe, set_do, clr_do, cause_clr;
    logic [NPINS-1:0] oe_q, do_q;
    logic [NPINS-1:0] pin_s;
    logic [NPINS-1:0] rise_q, fall_q, evmask_q;
    logic [NPINS-1:0] cause_q, cause_vis;
    logic             irq_q;
    logic [DW-1:0]    rd_mux;

    // Widen a pin vector to the bus, upper bits zero
    function automatic logic [DW-1:0] zext(input logic [NPINS-1:0] v);
        logic [DW-1:0] r;
        r = '0;
        r[NPINS-1:0] = v;
        return r;
    endfunction

    // Write decode per region
    always_comb begin
        wbits    = bus_wdata[NPINS-1:0];
        wr_cfg   = bus_wr && (bus_region == RGN_CFG);
        wr_cause = bus_wr && (bus_region == RGN_CAUSE);
        wr_set   = bus_wr && (bus_region == RGN_SET);
        wr_clr   = bus_wr && (bus_region == RGN_CLR);
        set_oe   = (wr_set && bus_addr == OFF_OE)   ? wbits : '0;
        set_do   = (wr_set && bus_addr == OFF_DOUT) ? wbits : '0;
        clr_oe   = (wr_clr && bus_addr == OFF_OE)   ? wbits : '0;
        clr_do   = (wr_clr && bus_addr == OFF_DOUT) ? wbits : '0;
        cause_clr = (wr_cause && bus_addr == OFF_CAUSECLR) ? wbits : '0;
    end

    gpio_sync #(.W(NPINS), .STAGES(2)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (pad_i),
        .dout (pin_s)
    );

    gpio_out_regs #(.W(NPINS)) u_out (
        .clk   (clk),
        .rst_n (rst_n),
        .set_oe(set_oe),
        .clr_oe(clr_oe),
        .set_do(set_do),
        .clr_do(clr_do),
        .oe_q  (oe_q),
        .do_q  (do_q),
        .pad_o (pad_o),
        .pad_oe(pad_oe)
    );

    // Rising and falling edge enables, plain read/write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rise_q <= '0;
            fall_q <= '0;
        end else if (wr_cfg) begin
            if (bus_addr == OFF_RISE) rise_q <= wbits;
            if (bus_addr == OFF_FALL) fall_q <= wbits;
        end
    end

    // Event-enable mask, plain read/write
    always_ff @(posedge clk) begin
        if (!rst_n)                                 evmask_q <= '0;
        else if (wr_cause && bus_addr == OFF_EVMASK) evmask_q <= wbits;
    end

    gpio_edge_cause #(.W(NPINS)) u_cause (
        .clk    (clk),
        .rst_n  (rst_n),
        .din_s  (pin_s),
        .rise_en(rise_q),
        .fall_en(fall_q),
        .clr    (cause_clr),
        .cause_q(cause_q)
    );

    // Visible causes after masking
    always_comb cause_vis = cause_q & evmask_q;

    // Registered shared interrupt level
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= |cause_vis;
    end
    assign irq = irq_q;

    // Read mux across regions and offsets
    always_comb begin
        rd_mux = '0;
        unique case (bus_region)
            RGN_CFG: begin
                if (bus_addr == OFF_RISE)      rd_mux = zext(rise_q);
                else if (bus_addr == OFF_FALL) rd_mux = zext(fall_q);
                else if (bus_addr == OFF_PIN)  rd_mux = zext(pin_s);
            end
            RGN_CAUSE: begin
                if (bus_addr == OFF_VIS)         rd_mux = zext(cause_vis);
                else if (bus_addr == OFF_EVMASK) rd_mux = zext(evmask_q);
            end
            default: begin
                if (bus_addr == OFF_OE)        rd_mux = zext(oe_q);
                else if (bus_addr == OFF_DOUT) rd_mux = zext(do_q);
            end
        endcase
        bus_rdata = bus_rd ? rd_mux : '0;
    end

    assert_irq_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_region == RGN_CAUSE && bus_addr == OFF_VIS && bus_rdata != '0) |=> irq);

    assert_irq_reset_R10: assert property (@(posedge clk)
        !rst_n |=> !irq);
endmodule

// File: tb/sim_gpio_edge_ctrl.sv
`timescale 1ns/1ps
module sim_gpio_edge_ctrl;
    localparam int NP = 24;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    bus_region = '0;
    logic [4:0]    bus_addr = '0;
    logic          bus_wr = 1'b0;
    logic          bus_rd = 1'b0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [NP-1:0] pad_i = '0;
    logic [NP-1:0] pad_o, pad_oe;
    logic          irq;

    int n_run  = 0;
    int n_fail = 0;

    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #10 clk = ~clk;

    gpio_edge_ctrl #(.NPINS(NP)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_region(bus_region), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pad_i(pad_i), .pad_o(pad_o), .pad_oe(pad_oe), .irq(irq)
    );

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Monitor: compares each read against the next queued expectation
    always @(negedge clk) begin
        if (bus_rd) begin
            if (exp_q.size() == 0) begin
                n_run++; n_fail++;
                $display("FAIL scoreboard actual=%h expected=none", bus_rdata);
            end else begin
                chk(bus_rdata, exp_q.pop_front(), tag_q.pop_front());
            end
        end
    end

    task automatic wr(input logic [1:0] rg, input logic [4:0] ad, input logic [31:0] d);
        bus_region = rg; bus_addr = ad; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk); #1;
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [1:0] rg, input logic [4:0] ad, input logic [31:0] e, input string tag);
        exp_q.push_back(e); tag_q.push_back(tag);
        bus_region = rg; bus_addr = ad; bus_rd = 1'b1;
        @(posedge clk); #1;
        bus_rd = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
        end
        #1;
    endtask

    initial begin
        #(200000 * 20);
        n_run++; n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        // R10: everything cleared by reset
        rd(2, 5'h00, 32'h0, "R10 oe");
        rd(3, 5'h04, 32'h0, "R10 dout");
        rd(0, 5'h00, 32'h0, "R10 rise");
        rd(0, 5'h04, 32'h0, "R10 fall");
        rd(1, 5'h14, 32'h0, "R10 evmask");
        rd(1, 5'h00, 32'h0, "R10 cause");
        chk(32'(pad_oe), 32'h0, "R10 pad_oe");
        chk(32'(irq), 32'h0, "R10 irq");

        // R1: set window
        wr(2, 5'h00, 32'hF0);
        rd(2, 5'h00, 32'hF0, "R1 oe set");
        wr(2, 5'h00, 32'h03);
        rd(2, 5'h00, 32'hF3, "R1 zeros keep");
        wr(2, 5'h04, 32'hA5);
        rd(3, 5'h04, 32'hA5, "R1 dout set");
        // R3: pad drive
        chk(32'(pad_oe), 32'hF3, "R3 pad_oe");
        chk(32'(pad_o), 32'hA1, "R3 pad_o");
        // R2: clear window
        wr(3, 5'h00, 32'h10);
        rd(2, 5'h00, 32'hE3, "R2 oe clear");
        wr(3, 5'h04, 32'h01);
        rd(2, 5'h04, 32'hA4, "R2 dout clear");
        chk(32'(pad_o), 32'hA0, "R3 pad_o after clear");
        // R9: unimplemented bits
        wr(2, 5'h00, 32'hFF00_0000);
        rd(2, 5'h00, 32'hE3, "R9 upper oe ignored");
        wr(0, 5'h00, 32'hFFFF_FFFF);
        rd(0, 5'h00, 32'h00FF_FFFF, "R9 rise width");
        wr(0, 5'h00, 32'h0);

        // R4: synchroniser latency
        pad_i = 24'h123456;
        @(posedge clk); #1;
        rd(0, 5'h08, 32'h0, "R4 not yet");
        rd(0, 5'h08, 32'h0012_3456, "R4 synced");
        pad_i = '0;
        idle(4);
        rd(1, 5'h00, 32'h0, "R5 no enables no cause");

        // R5: edge enables
        wr(0, 5'h00, 32'h5);
        wr(0, 5'h04, 32'h6);
        wr(1, 5'h14, 32'hF);
        pad_i = 24'hF;
        idle(5);
        rd(1, 5'h00, 32'h5, "R5 rising");
        wr(1, 5'h18, 32'hF);
        rd(1, 5'h00, 32'h0, "R7 clear");
        pad_i = '0;
        idle(5);
        rd(1, 5'h00, 32'h6, "R5 falling");
        chk(32'(irq), 32'h1, "R8 irq high");
        wr(1, 5'h18, 32'hF);
        idle(1);
        chk(32'(irq), 32'h0, "R8 irq low");

        // R6: masked sticky cause, stale clear while masked
        wr(1, 5'h14, 32'h0);
        pad_i = 24'h1;
        idle(5);
        rd(1, 5'h00, 32'h0, "R6 masked read");
        chk(32'(irq), 32'h0, "R6 masked irq");
        wr(1, 5'h14, 32'h1);
        rd(1, 5'h00, 32'h1, "R6 unmasked sticky");
        chk(32'(irq), 32'h1, "R8 irq on unmask");
        wr(1, 5'h14, 32'h0);
        wr(1, 5'h18, 32'h1);
        wr(1, 5'h14, 32'h1);
        rd(1, 5'h00, 32'h0, "R6 stale cleared");
        idle(1);
        chk(32'(irq), 32'h0, "R6 irq after stale clear");

        // R7: zero write ignored
        pad_i = '0;
        idle(4);
        pad_i = 24'h1;
        idle(5);
        wr(1, 5'h18, 32'h0);
        rd(1, 5'h00, 32'h1, "R7 zero write");
        wr(1, 5'h18, 32'h1);
        pad_i = '0;
        idle(4);
        rd(1, 5'h00, 32'h0, "R7 cleared before race");
        // R7: edge and clear in the same cycle, edge wins
        pad_i = 24'h1;
        @(posedge clk);
        @(posedge clk); #1;
        wr(1, 5'h18, 32'h1);
        rd(1, 5'h00, 32'h1, "R7 edge beats clear");

        idle(2);
        if (exp_q.size() != 0) begin
            n_run++; n_fail++;
            $display("FAIL scoreboard actual=%0d expected=0 pending", exp_q.size());
        end
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule